// File: doc/BRIEF.md
# Dual-Rail Completion Detector with Early-Done Option

This block watches a parameterised word of dual-rail bits and raises one `done` flag for a pipeline stage. Each bit travels on a rail pair. One code is the empty spacer, two codes carry a valid zero or one, and the fourth code is illegal. Each pair is reduced to a per-bit valid or spacer indication. A balanced tree of agreement nodes then merges these indications, and a single state bit settles the result. Together the tree and the state bit behave like a multi-input Muller C-element.

A parameter selects one of two variants. The plain variant is symmetric. `done` rises once every bit holds a valid code, falls once every bit is back at spacer, and otherwise keeps its value. The early-done variant uses an asymmetric element that also sees the stage's precharge control. It sets only while the stage evaluates and every bit is valid. It clears the moment precharge is requested, whatever the rails show. A downstream controller can therefore learn about a precharge without waiting for the data to drain.

The state element is a clocked flop with an asynchronous active-low reset, so it can be synthesized. `done` changes on the clock edge that follows the qualifying input condition. The error flag is combinational.

Top module: `dr_done_detect`

## Requirements
- R1: Bit i of the word is the rail pair `rails_i[2i+1:2i]`. The code 00 is spacer, 01 is a valid zero, 10 is a valid one, and 11 is illegal.
- R2: `err_o` is 1 in the same cycle whenever any pair holds 11, and 0 otherwise.
- R3: A pair holding 11 never counts as valid, so `done_o` cannot rise while any pair is 11.
- R4: `done_o` takes its new value on the rising clock edge after the inputs that cause the change, with one cycle of latency.
- R5: In the plain variant (`EARLY=0`), `done_o` becomes 1 after a cycle in which every pair is valid.
- R6: In the plain variant, `done_o` becomes 0 after a cycle in which every pair is 00.
- R7: In the plain variant, `done_o` keeps its value when the word mixes valid and spacer codes.
- R8: In the plain variant, `pc_i` has no effect on `done_o`.
- R9: In the early variant (`EARLY=1`), `done_o` becomes 1 only after a cycle with `pc_i`=0 and every pair valid. It does not become 1 while `pc_i`=1.
- R10: In the early variant, `done_o` becomes 0 after any cycle with `pc_i`=1, whatever the rails hold.
- R11: In the early variant, `done_o` keeps its value when `pc_i`=0 and not every pair is valid.
- R12: `rst_n`=0 forces `done_o` to 0 at once and clears the state.
- R13: The tree is built for any width `W` of at least 1, including widths that are not powers of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the state element |
| rst_n | input | 1 | Asynchronous active-low reset |
| rails_i | input | 2*W | Dual-rail word, pair i at bits 2i+1:2i |
| pc_i | input | 1 | Precharge request of the stage (1 = precharge, 0 = evaluate) |
| done_o | output | 1 | Completion flag |
| err_o | output | 1 | Any pair holds the illegal code 11 |

## Verification
The bound assertions check the following on every cycle:
- `err_o` matches a scan of the rails for the illegal code.
- An illegal pair never counts as valid.
- A rise of `done_o` is always preceded by a fully valid word, and in the early variant also by evaluate.
- In the early variant, a precharge request is always followed by a low `done_o`.
- In the plain variant, `done_o` falls only after an all-spacer word.
- `done_o` stays put whenever neither the set nor the clear condition holds.

The bench's directed scenarios are needed for the rest:
- Precharge is ignored in the plain variant while the early variant drops at once.
- A single illegal bit blocks the set.
- Reset takes effect in the middle of a run.
- Widths of 1 and 3 build correct trees, shown by a behavioural model of the same sequences.

// File: rtl/dr_done_pkg.sv
package dr_done_pkg;

  typedef enum logic [1:0] {
    RAIL_SPACER = 2'b00,
    RAIL_ZERO   = 2'b01,
    RAIL_ONE    = 2'b10,
    RAIL_BAD    = 2'b11
  } rail_code_e;

  // A pair is valid only for a single high rail.
  function automatic logic pair_valid(input logic [1:0] p);
    return (p == RAIL_ZERO) || (p == RAIL_ONE);
  endfunction

  function automatic logic pair_spacer(input logic [1:0] p);
    return p == RAIL_SPACER;
  endfunction

  function automatic logic pair_illegal(input logic [1:0] p);
    return p == RAIL_BAD;
  endfunction

  // Next value of a C-element given its set, clear and previous state.
  function automatic logic c_next(input logic set_c, input logic clr_c, input logic prev);
    if (set_c)      return 1'b1;
    else if (clr_c) return 1'b0;
    else            return prev;
  endfunction

endpackage

// File: rtl/dr_rail_sense.sv
module dr_rail_sense
  import dr_done_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [2*W-1:0] rails_i,
  output logic [W-1:0]   valid_o,
  output logic [W-1:0]   spacer_o,
  output logic [W-1:0]   illegal_o
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] pair_w;
    assign pair_w       = rails_i[2*i +: 2];
    assign valid_o[i]   = pair_valid(pair_w);
    assign spacer_o[i]  = pair_spacer(pair_w);
    assign illegal_o[i] = pair_illegal(pair_w);
  end

endmodule

// File: rtl/dr_agree_tree.sv
module dr_agree_tree #(
  parameter int W = 4
) (
  input  logic [W-1:0] up_i,
  input  logic [W-1:0] dn_i,
  output logic         all_up_o,
  output logic         all_dn_o
);

  localparam int LVL    = (W > 1) ? $clog2(W) : 0;
  localparam int LEAVES = 1 << LVL;

  // Heap-ordered nodes: root at 1, leaves from LEAVES to 2*LEAVES-1.
  logic [2*LEAVES-1:1] up_n;
  logic [2*LEAVES-1:1] dn_n;

  for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
    if (i < W) begin : g_real
      assign up_n[LEAVES+i] = up_i[i];
      assign dn_n[LEAVES+i] = dn_i[i];
    end else begin : g_pad
      assign up_n[LEAVES+i] = 1'b1;
      assign dn_n[LEAVES+i] = 1'b1;
    end
  end

  for (genvar k = 1; k < LEAVES; k++) begin : g_node
    assign up_n[k] = up_n[2*k] & up_n[2*k+1];
    assign dn_n[k] = dn_n[2*k] & dn_n[2*k+1];
  end

  assign all_up_o = up_n[1];
  assign all_dn_o = dn_n[1];

endmodule

// File: rtl/dr_cstate.sv
module dr_cstate
  import dr_done_pkg::*;
#(
  parameter bit EARLY = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic all_up_i,
  input  logic all_dn_i,
  input  logic pc_i,
  output logic set_o,
  output logic clr_o,
  output logic state_o
);

  if (EARLY) begin : g_asym
    assign set_o = all_up_i & ~pc_i;
    assign clr_o = pc_i;
  end else begin : g_sym
    logic pc_unused;
    assign pc_unused = pc_i;
    assign set_o = all_up_i;
    assign clr_o = all_dn_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_o <= 1'b0;
    else        state_o <= c_next(set_o, clr_o, state_o);
  end

endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect #(
  parameter int W     = 4,
  parameter bit EARLY = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2*W-1:0] rails_i,
  input  logic         pc_i,
  output logic         done_o,
  output logic         err_o
);

  logic [W-1:0] bit_valid_w;
  logic [W-1:0] bit_spacer_w;
  logic [W-1:0] bit_illegal_w;
  logic         all_valid_w;
  logic         all_spacer_w;
  logic         set_w;
  logic         clr_w;

  dr_rail_sense #(.W(W)) u_sense (
    .rails_i   (rails_i),
    .valid_o   (bit_valid_w),
    .spacer_o  (bit_spacer_w),
    .illegal_o (bit_illegal_w)
  );

  dr_agree_tree #(.W(W)) u_tree (
    .up_i     (bit_valid_w),
    .dn_i     (bit_spacer_w),
    .all_up_o (all_valid_w),
    .all_dn_o (all_spacer_w)
  );

  dr_cstate #(.EARLY(EARLY)) u_state (
    .clk      (clk),
    .rst_n    (rst_n),
    .all_up_i (all_valid_w),
    .all_dn_i (all_spacer_w),
    .pc_i     (pc_i),
    .set_o    (set_w),
    .clr_o    (clr_w),
    .state_o  (done_o)
  );

  assign err_o = |bit_illegal_w;

endmodule

// File: rtl/dr_done_detect_chk.sv
module dr_done_detect_chk #(
  parameter int W     = 4,
  parameter bit EARLY = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2*W-1:0] rails_i,
  input logic           pc_i,
  input logic           done_o,
  input logic           err_o,
  input logic           all_valid_w,
  input logic           all_spacer_w,
  input logic           set_w,
  input logic           clr_w
);

  logic any_bad;
  always_comb begin
    any_bad = 1'b0;
    for (int i = 0; i < W; i++)
      if (rails_i[2*i +: 2] == 2'b11) any_bad = 1'b1;
  end

  p_err_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o == any_bad);

  p_bad_not_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    any_bad |-> !all_valid_w);

  p_rise_after_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(all_valid_w));

  p_rise_in_eval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (EARLY && $rose(done_o)) |-> !$past(pc_i));

  p_drop_on_pc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (EARLY && pc_i) |=> !done_o);

  p_fall_after_spacer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!EARLY && $fell(done_o)) |-> $past(all_spacer_w));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_w && !clr_w) |=> $stable(done_o));

  p_reset_low_r12: assert property (@(posedge clk)
    !rst_n |-> !done_o);

endmodule

bind dr_done_detect dr_done_detect_chk #(.W(W), .EARLY(EARLY)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rails_i      (rails_i),
  .pc_i         (pc_i),
  .done_o       (done_o),
  .err_o        (err_o),
  .all_valid_w  (all_valid_w),
  .all_spacer_w (all_spacer_w),
  .set_w        (set_w),
  .clr_w        (clr_w)
);

// File: tb/dr_done_detect_bench.sv
module dr_done_detect_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] rails = 8'h00;
  logic       pc = 1'b0;
  logic       done4, err4, done3, err3, done1, err1;
  int         checks = 0;
  int         failures = 0;
  string      tag = "R12";
  logic       m4 = 1'b0, m3 = 1'b0, m1 = 1'b0;

  always #5 clk = ~clk;

  dr_done_detect #(.W(4), .EARLY(1'b1)) u_dr_done_detect (
    .clk(clk), .rst_n(rst_n), .rails_i(rails), .pc_i(pc), .done_o(done4), .err_o(err4));
  dr_done_detect #(.W(3), .EARLY(1'b0)) u_plain3 (
    .clk(clk), .rst_n(rst_n), .rails_i(rails[5:0]), .pc_i(pc), .done_o(done3), .err_o(err3));
  dr_done_detect #(.W(1), .EARLY(1'b1)) u_one (
    .clk(clk), .rst_n(rst_n), .rails_i(rails[1:0]), .pc_i(pc), .done_o(done1), .err_o(err1));

  // Behavioural reference: count codes, then apply the mode's rule.
  function automatic logic ref_err(int w, logic [7:0] r);
    for (int i = 0; i < w; i++) if (r[2*i +: 2] == 2'b11) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic ref_next(int w, bit early, logic [7:0] r, logic p, logic prev);
    int nv = 0;
    int ns = 0;
    for (int i = 0; i < w; i++) begin
      if (r[2*i +: 2] == 2'b01 || r[2*i +: 2] == 2'b10) nv++;
      if (r[2*i +: 2] == 2'b00) ns++;
    end
    if (early) begin
      if (p) return 1'b0;
      if (nv == w) return 1'b1;
      return prev;
    end
    if (nv == w) return 1'b1;
    if (ns == w) return 1'b0;
    return prev;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m4 <= 1'b0; m3 <= 1'b0; m1 <= 1'b0;
    end else begin
      m4 <= ref_next(4, 1'b1, rails, pc, m4);
      m3 <= ref_next(3, 1'b0, rails, pc, m3);
      m1 <= ref_next(1, 1'b1, rails, pc, m1);
    end
  end

  task automatic check1(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Compare every cycle, away from the active edge (R4 latency is implied).
  always @(negedge clk) begin
    check1("R4 early W4 done", done4, m4);
    check1("R8 plain W3 done", done3, m3);
    check1("R13 W1 done", done1, m1);
    check1("R2 W4 err", err4, ref_err(4, rails));
    check1("R2 W3 err", err3, ref_err(3, rails));
    check1("R2 W1 err", err1, ref_err(1, rails));
  end

  task automatic step(logic [7:0] r, logic p, string t);
    @(negedge clk);
    #1;
    rails = r;
    pc = p;
    tag = t;
  endtask

  localparam logic [7:0] ALLV = 8'b01_10_01_10;

  initial begin
    tag = "R12";
    rails = ALLV;
    pc = 1'b0;
    repeat (3) @(negedge clk);
    check1("R12 reset done", done4, 1'b0);
    #1 rst_n = 1'b1;
    step(ALLV, 1'b0, "R1/R5/R9 set");
    step(ALLV, 1'b0, "R9 set");
    @(negedge clk);
    check1("R9 early set", done4, 1'b1);
    check1("R5 plain set", done3, 1'b1);
    step(ALLV, 1'b1, "R10/R8 pc with valid data");
    @(negedge clk);
    check1("R10 early drops", done4, 1'b0);
    check1("R8 plain ignores pc", done3, 1'b1);
    step(8'b00_00_01_00, 1'b1, "R10 partial spacer");
    step(8'b00_10_00_01, 1'b0, "R11/R7 mixed hold");
    @(negedge clk);
    check1("R11 early holds", done4, 1'b0);
    check1("R7 plain holds", done3, 1'b1);
    step(8'h00, 1'b0, "R6 all spacer");
    @(negedge clk);
    check1("R6 plain clears", done3, 1'b0);
    step(ALLV, 1'b1, "R9 no set in precharge");
    @(negedge clk);
    check1("R9 no set while pc", done4, 1'b0);
    check1("R8 plain sets under pc", done3, 1'b1);
    step(8'b01_10_01_11, 1'b0, "R3 illegal bit");
    @(negedge clk);
    check1("R3 illegal blocks set", done4, 1'b0);
    check1("R2 illegal flagged", err4, 1'b1);
    step(8'b01_10_01_10, 1'b0, "R9 set after fix");
    @(negedge clk);
    check1("R9 set after fix", done4, 1'b1);
    #1 rst_n = 1'b0;
    tag = "R12";
    #2 check1("R12 mid-run reset", done4, 1'b0);
    check1("R12 mid-run reset plain", done3, 1'b0);
    @(negedge clk);
    #1 rst_n = 1'b1;
    begin
      logic [15:0] lf = 16'hACE1;
      for (int n = 0; n < 400; n++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        step(lf[7:0], lf[9] & lf[11], "R4 random");
      end
    end
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule